// File: doc/BRIEF.md
# Packet Buffer Pointer Data Port

This block gives a host a byte-wide window into a packet buffer made of 2 KB pages. The host loads a 16-bit pointer through two byte registers, then reads or writes the buffer through a four-byte data window. The block turns the pointer and the window byte into a page number and an 11-bit byte address for an external buffer RAM. It drives a one-cycle write strobe for window writes and passes the RAM's read byte back to the host.

Two flag bits in the pointer set how it is used. Bit 15 chooses the page source. When it is set, the page is the head of the receive queue. When it is clear, the page is the host's packet number. Both page sources arrive as inputs. Bit 14 chooses between two modes. In the fixed mode the pointer stays put and the window byte selects one of four neighbouring bytes. In the streaming mode every window access uses the pointer offset and then advances it by one.

Top module: `pbuf_ptr_port`

## Requirements
- R1: After a synchronous active-low reset the pointer is zero, so reads of offset 6 and offset 7 both return 0x00.
- R2: A host write to offset 6 replaces pointer bits 7:0 and a write to offset 7 replaces pointer bits 15:8. Each write leaves the other byte unchanged.
- R3: A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7, so bit 3 of that byte always reads 0. The stored bit 11 is kept.
- R4: In fixed mode (pointer bit 14 = 0) the byte address is pointer bits 10:0 plus the window index (host offset minus 8, range 0 to 3), taken modulo 2048. Pointer bits 15:11 never enter the address.
- R5: When pointer bit 15 = 1 the page output equals the receive-queue head input. When it is 0 the page output equals the packet-number input. The selection follows the inputs in the same cycle.
- R6: In streaming mode (pointer bit 14 = 1) a window access uses pointer bits 10:0 as the address, without adding the window index. After the access the offset increases by one. This holds for both reads and writes.
- R7: The streaming increment wraps from 2047 to 0 and leaves pointer bits 15:11 unchanged.
- R8: In fixed mode, window reads and writes leave the pointer unchanged.
- R9: A host write to any of offsets 8 to 11 asserts the buffer write strobe for exactly that cycle, with the host byte as write data. A write to any other offset never asserts the strobe.
- R10: A host read of offsets 8 to 11 returns the buffer read byte in the same cycle. A read of an offset outside 6 to 11 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register offset of the host access |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| rxq_head | input | 2 | Page at the head of the receive queue |
| pkt_num | input | 2 | Host-selected packet page |
| buf_page | output | 2 | Page address to the buffer RAM |
| buf_ofs | output | 11 | Byte address inside the page |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer read byte at the current address |

## Verification
In streaming mode, a window write stores its byte and advances the pointer at the same clock edge. The write address must use the offset from before that edge. The bench provokes this with back-to-back window writes across the 2047-to-0 boundary, each with its expected page and address queued for the scoreboard. It then reads the pointer back to judge the increment and the flag bits that must survive it. A streaming read runs the same race between returned data and pointer advance. The bench checks that each returned byte comes from the address before the increment.

// File: rtl/pbuf_ptr_pkg.sv
// Package: shared register-select type for the pointer data port.
package pbuf_ptr_pkg;
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_PTR_LO = 2'd1,
        SEL_PTR_HI = 2'd2,
        SEL_DATA   = 2'd3
    } pbuf_sel_e;
endpackage

// File: rtl/pbuf_ptr_decode.sv
// Module: pbuf_ptr_decode
// Decodes the host register offset into a register select and a window index.
// Assumes the pointer sits at PTR_ADDR (low) and PTR_ADDR+1 (high), and the
// data window covers WIN_BYTES consecutive offsets from WIN_BASE.
module pbuf_ptr_decode
    import pbuf_ptr_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PTR_ADDR  = 6,
    parameter int WIN_BASE  = 8,
    parameter int WIN_BYTES = 4,
    localparam int WIN_W    = $clog2(WIN_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output pbuf_sel_e         sel,
    output logic [WIN_W-1:0]  win_idx
);
    localparam int WIN_END = WIN_BASE + WIN_BYTES;

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] rel;

    assign addr_x = {1'b0, addr};
    assign rel    = addr_x - (ADDR_W+1)'(WIN_BASE);

    // Classify the offset into pointer byte, data window or nothing.
    always_comb begin
        if (addr_x == (ADDR_W+1)'(PTR_ADDR))
            sel = SEL_PTR_LO;
        else if (addr_x == (ADDR_W+1)'(PTR_ADDR + 1))
            sel = SEL_PTR_HI;
        else if (addr_x >= (ADDR_W+1)'(WIN_BASE) && addr_x < (ADDR_W+1)'(WIN_END))
            sel = SEL_DATA;
        else
            sel = SEL_NONE;
    end

    // Window byte index relative to the window base.
    assign win_idx = rel[WIN_W-1:0];
endmodule

// File: rtl/pbuf_ptr_reg.sv
// Module: pbuf_ptr_reg
// Holds the pointer register. Byte lanes are written independently. In
// streaming mode a window access advances the offset field, wrapping inside
// OFS_W bits. Assumes a pointer byte write and a window access never happen
// in the same cycle (one host offset per cycle).
module pbuf_ptr_reg #(
    parameter int PTR_W    = 16,
    parameter int OFS_W    = 11,
    parameter int AUTO_BIT = 14,
    localparam int LANES   = PTR_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_we,
    input  logic [7:0]       wdata,
    input  logic             access,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_lanes;
    logic [PTR_W-1:0] ptr_d;
    logic             step;

    // Per-lane merge of host byte writes.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign ptr_lanes[b*8 +: 8] = lane_we[b] ? wdata : ptr_q[b*8 +: 8];
    end

    assign step = access && ptr_q[AUTO_BIT] && (lane_we == '0);

    // Next pointer: host bytes, or an offset step that keeps the flags.
    always_comb begin
        ptr_d = ptr_lanes;
        if (step)
            ptr_d[OFS_W-1:0] = ptr_q[OFS_W-1:0] + 1'b1;
    end

    // Pointer register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R7: flag bits survive a streaming step.
    a_r7_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (access && ptr[AUTO_BIT] && lane_we == '0)
        |=> ptr[PTR_W-1:OFS_W] == $past(ptr[PTR_W-1:OFS_W]));

    // R6: a streaming access advances the offset by exactly one.
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (access && ptr[AUTO_BIT] && lane_we == '0)
        |=> ptr[OFS_W-1:0] == OFS_W'($past(ptr[OFS_W-1:0]) + 1));

    // R8: a fixed-mode access leaves the pointer unchanged.
    a_r8_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !ptr[AUTO_BIT] && lane_we == '0) |=> $stable(ptr));

    // R2: a low-byte write keeps the high byte.
    a_r2_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we == LANES'(1)) |=> ptr[PTR_W-1:8] == $past(ptr[PTR_W-1:8]));
endmodule

// File: rtl/pbuf_ptr_addr.sv
// Module: pbuf_ptr_addr
// Forms the buffer page and byte address from the pointer. Assumes both page
// sources are valid whenever a window access is made.
module pbuf_ptr_addr #(
    parameter int PTR_W    = 16,
    parameter int OFS_W    = 11,
    parameter int PAGE_W   = 2,
    parameter int WIN_W    = 2,
    parameter int RX_BIT   = 15,
    parameter int AUTO_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [WIN_W-1:0]  win_idx,
    input  logic [PAGE_W-1:0] rxq_head,
    input  logic [PAGE_W-1:0] pkt_num,
    output logic [PAGE_W-1:0] page,
    output logic [OFS_W-1:0]  ofs
);
    logic [OFS_W-1:0] idx_x;

    assign idx_x = {{(OFS_W-WIN_W){1'b0}}, win_idx};

    // Page source chosen by the receive-select flag.
    always_comb begin
        page = ptr[RX_BIT] ? rxq_head : pkt_num;
    end

    // Byte address: streaming uses the pointer alone, fixed adds the index.
    always_comb begin
        if (ptr[AUTO_BIT])
            ofs = ptr[OFS_W-1:0];
        else
            ofs = ptr[OFS_W-1:0] + idx_x;
    end

    // R5: page tracks the receive head when selected.
    a_r5_rx_page: assert property (@(posedge clk) disable iff (!rst_n)
        ptr[RX_BIT] |-> page == rxq_head);

    // R4: index 0 in fixed mode addresses the pointer offset itself.
    a_r4_base_ofs: assert property (@(posedge clk) disable iff (!rst_n)
        (win_idx == '0) |-> ofs == ptr[OFS_W-1:0]);
endmodule

// File: rtl/pbuf_ptr_port.sv
// Module: pbuf_ptr_port (top)
// Host byte port into a paged packet buffer: a pointer register plus a data
// window that drives an external buffer RAM. Assumes at most one host offset
// per cycle. A cycle with both strobes counts as one access and as a write.
module pbuf_ptr_port
    import pbuf_ptr_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PAGE_W    = 2,
    parameter int OFS_W     = 11,
    parameter int PTR_ADDR  = 6,
    parameter int WIN_BASE  = 8,
    parameter int WIN_BYTES = 4,
    parameter logic [7:0] HI_RD_MASK = 8'hF7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [PAGE_W-1:0] rxq_head,
    input  logic [PAGE_W-1:0] pkt_num,
    output logic [PAGE_W-1:0] buf_page,
    output logic [OFS_W-1:0]  buf_ofs,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    localparam int PTR_W    = 16;
    localparam int RX_BIT   = PTR_W - 1;
    localparam int AUTO_BIT = PTR_W - 2;
    localparam int WIN_W    = $clog2(WIN_BYTES);
    localparam int LANES    = PTR_W / 8;

    pbuf_sel_e        sel;
    logic [WIN_W-1:0] win_idx;
    logic [PTR_W-1:0] ptr;
    logic [LANES-1:0] lane_we;
    logic             access;

    pbuf_ptr_decode #(
        .ADDR_W(ADDR_W), .PTR_ADDR(PTR_ADDR),
        .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
    ) u_dec (
        .addr(host_addr), .sel(sel), .win_idx(win_idx)
    );

    // Host byte-lane strobes for the pointer register.
    always_comb begin
        lane_we    = '0;
        lane_we[0] = host_wr && (sel == SEL_PTR_LO);
        lane_we[1] = host_wr && (sel == SEL_PTR_HI);
    end

    // A window access is any strobe aimed at the data window.
    assign access = (host_wr || host_rd) && (sel == SEL_DATA);

    pbuf_ptr_reg #(
        .PTR_W(PTR_W), .OFS_W(OFS_W), .AUTO_BIT(AUTO_BIT)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n), .lane_we(lane_we),
        .wdata(host_wdata), .access(access), .ptr(ptr)
    );

    pbuf_ptr_addr #(
        .PTR_W(PTR_W), .OFS_W(OFS_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W),
        .RX_BIT(RX_BIT), .AUTO_BIT(AUTO_BIT)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .ptr(ptr), .win_idx(win_idx),
        .rxq_head(rxq_head), .pkt_num(pkt_num),
        .page(buf_page), .ofs(buf_ofs)
    );

    // Buffer write strobe and data.
    assign buf_we    = host_wr && (sel == SEL_DATA);
    assign buf_wdata = host_wdata;

    // Host read mux.
    always_comb begin
        unique case (sel)
            SEL_PTR_LO: host_rdata = ptr[7:0];
            SEL_PTR_HI: host_rdata = ptr[15:8] & HI_RD_MASK;
            SEL_DATA:   host_rdata = buf_rdata;
            default:    host_rdata = 8'h00;
        endcase
    end

    // R3: the masked high-byte bit never reads as one.
    a_r3_hi_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PTR_HI) |-> host_rdata[3] == 1'b0);

    // R9: the buffer strobe only follows a host write.
    a_r9_we_from_host: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> host_wr && buf_wdata == host_wdata);

    // R10: offsets outside the port read as zero.
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> host_rdata == 8'h00);
endmodule

// File: tb/sim_pbuf_ptr_port.sv
// Scoreboard bench for pbuf_ptr_port with a behavioural buffer RAM.
module sim_pbuf_ptr_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [1:0]  rxq_head = '0;
    logic [1:0]  pkt_num = '0;
    logic [1:0]  buf_page;
    logic [10:0] buf_ofs;
    logic        buf_we;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0]  page;
        logic [10:0] ofs;
        logic [7:0]  data;
        string       tag;
    } wr_item_t;
    wr_item_t exp_q[$];

    logic [7:0] ram [int];
    bit         ram_tick = 1'b0;

    always #4 clk = ~clk;

    pbuf_ptr_port u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rxq_head(rxq_head), .pkt_num(pkt_num), .buf_page(buf_page),
        .buf_ofs(buf_ofs), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    // Behavioural buffer RAM.
    always @(posedge clk) begin
        if (buf_we) begin
            ram[int'(buf_page) * 2048 + int'(buf_ofs)] = buf_wdata;
            ram_tick = ~ram_tick;
        end
    end

    always @(buf_page or buf_ofs or ram_tick) begin
        int k;
        k = int'(buf_page) * 2048 + int'(buf_ofs);
        buf_rdata = ram.exists(k) ? ram[k] : 8'h00;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected buffer write whenever the strobe shows.
    always begin
        @(negedge clk);
        #2;
        if (rst_n && buf_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected buffer write", int'(buf_ofs), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check(buf_page == it.page, {it.tag, " page"}, int'(buf_page), int'(it.page));
                check(buf_ofs == it.ofs, {it.tag, " offset"}, int'(buf_ofs), int'(it.ofs));
                check(buf_wdata == it.data, {it.tag, " data"}, int'(buf_wdata), int'(it.data));
            end
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic win_write(input logic [3:0] a, input logic [7:0] d,
                             input logic [1:0] pg, input logic [10:0] of, input string tag);
        wr_item_t it;
        it.page = pg; it.ofs = of; it.data = d; it.tag = tag;
        exp_q.push_back(it);
        reg_write(a, d);
    endtask

    task automatic reg_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #2;
        check(host_rdata == exp, tag, int'(host_rdata), int'(exp));
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic win_read(input logic [3:0] a, input logic [7:0] exp,
                            input logic [10:0] of, input string tag);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #2;
        check(buf_ofs == of, {tag, " offset"}, int'(buf_ofs), int'(of));
        check(host_rdata == exp, {tag, " data"}, int'(host_rdata), int'(exp));
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        reg_write(4'd6, p[7:0]);
        reg_write(4'd7, p[15:8]);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        reg_read(4'd6, 8'h00, "R1 ptr low after reset");
        reg_read(4'd7, 8'h00, "R1 ptr high after reset");

        // R2, R3: independent byte writes, masked high read.
        reg_write(4'd6, 8'h34);
        reg_write(4'd7, 8'h12);
        reg_read(4'd6, 8'h34, "R2 low byte");
        reg_read(4'd7, 8'h12, "R2 high byte");
        reg_write(4'd7, 8'h08);
        reg_read(4'd6, 8'h34, "R2 low kept after high write");
        reg_read(4'd7, 8'h00, "R3 bit 11 masked on read");

        // R4: stored bit 11 does not enter the address.
        pkt_num = 2'd2;
        win_write(4'd8, 8'h5A, 2'd2, 11'h034, "R4 bit11 excluded");

        // R4, R9: fixed mode, four window bytes.
        set_ptr(16'h0100);
        for (int i = 0; i < 4; i++)
            win_write(4'(8 + i), 8'hA0 + 8'(i), 2'd2, 11'h100 + 11'(i), "R9 fixed window write");
        reg_read(4'd6, 8'h00, "R8 ptr low held after writes");
        reg_read(4'd7, 8'h01, "R8 ptr high held after writes");

        // R10: window read returns buffer data.
        win_read(4'd10, 8'hA2, 11'h102, "R10 fixed window read");

        // R8: repeated fixed reads do not move the pointer.
        win_read(4'd9, 8'hA1, 11'h101, "R8 fixed read first");
        win_read(4'd9, 8'hA1, 11'h101, "R8 fixed read second");

        // R4: index sum wraps modulo 2048.
        set_ptr(16'h07FF);
        win_write(4'd10, 8'h77, 2'd2, 11'h001, "R4 index wrap");

        // R5: page source follows bit 15 and the queue head input.
        rxq_head = 2'd1;
        set_ptr(16'h8200);
        win_write(4'd9, 8'h11, 2'd1, 11'h201, "R5 rx head page");
        rxq_head = 2'd3;
        win_write(4'd8, 8'h22, 2'd3, 11'h200, "R5 rx head changed");

        // R6, R7: streaming writes across the wrap, flags kept.
        rxq_head = 2'd1;
        set_ptr(16'hC7FE);
        reg_read(4'd7, 8'hC7, "R3 high byte with bit3 clear");
        win_write(4'd11, 8'h31, 2'd1, 11'h7FE, "R6 stream write 0");
        win_write(4'd9, 8'h32, 2'd1, 11'h7FF, "R6 stream write 1");
        win_write(4'd8, 8'h33, 2'd1, 11'h000, "R7 stream write after wrap");
        reg_read(4'd6, 8'h01, "R7 offset after wrap");
        reg_read(4'd7, 8'hC0, "R7 flags kept");

        // R6: streaming reads advance, index ignored.
        set_ptr(16'h4100);
        win_read(4'd11, 8'hA0, 11'h100, "R6 stream read 0");
        win_read(4'd8, 8'hA1, 11'h101, "R6 stream read 1");
        reg_read(4'd6, 8'h02, "R6 offset after reads");

        // R9, R10: other offsets neither write the buffer nor read data.
        reg_write(4'd3, 8'hFF);
        reg_read(4'd3, 8'h00, "R10 outside offset reads zero");
        reg_read(4'd6, 8'h02, "R9 ptr untouched by outside write");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R9 all expected writes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule